// File: doc/BRIEF.md
# Unaligned Partial Word Merge Unit

This block forms the data half of the left and right partial load and store operations of a 64-bit core. Each operation moves the part of a register that belongs in one aligned word (32 bits) or doubleword (64 bits) of memory. The caller fetches the aligned memory operand first, at the address rounded down to 4 or 8 bytes. It presents that operand with the current register value, the low effective address bits, the operation kind, the size and the core's byte order. The block returns a merged value.

For loads the merged value is the new register contents. For stores it is the new memory contents, which are written back to the same aligned address. A per-byte write enable lets a byte-enabled memory skip the read half of the read-modify-write. These operations never check alignment, so no fault path exists.

The merge itself is combinational. A registering stage captures the result when a request is valid and presents it one cycle later. The result stays there until the next request arrives.

Top module: `pwm_merge_unit`

## Requirements
- R1: The byte index s comes from addr[1:0] for word operations (addr[2] has no effect) and from addr[2:0] for doubleword operations. The index is inverted (XOR with 3 for word, 7 for doubleword) for left operations when big_endian=0, and for right operations when big_endian=1.
- R2: Left load (op=0): register bits [W-1:8s] take memory bits [W-1-8s:0]. All other register bits keep their value. W is 32 for word operations and 64 for doubleword operations.
- R3: Right load (op=1): register bits [W-1-8s:0] take memory bits [W-1:8s]. All other register bits keep their value.
- R4: Left store (op=2): memory bits [W-1-8s:0] take register bits [W-1:8s]. All other memory bits keep their value.
- R5: Right store (op=3): memory bits [W-1:8s] take register bits [W-1-8s:0]. All other memory bits keep their value.
- R6: A word load result is sign-extended from bit 31 to 64 bits. A word store result has bits [63:32] zero. Word operations use only bits [31:0] of the register and memory inputs.
- R7: For stores, out_be bit b is 1 exactly when memory byte b (bits [8b+7:8b]) takes register data. For loads, out_be is all zero. For word stores, out_be[7:4] is zero.
- R8: out_valid is 1 in the cycle after a cycle with in_valid=1 and is 0 otherwise. out_data and out_be change only after a cycle with in_valid=1.
- R9: While rst_n is low, out_valid, out_data and out_be are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| in_addr | input | 3 | Low effective address bits |
| in_big_endian | input | 1 | 1 = big-endian core |
| in_op | input | 2 | 0 left load, 1 right load, 2 left store, 3 right store |
| in_dbl | input | 1 | 1 = doubleword, 0 = word |
| in_reg | input | 64 | Current register value |
| in_mem | input | 64 | Aligned memory operand (word in bits [31:0]) |
| out_valid | output | 1 | Result presented |
| out_data | output | 64 | Merged register value (loads) or memory value (stores) |
| out_be | output | 8 | Memory byte write enables (stores) |

## Verification
The bench sweeps every combination of operation, size, address value and byte order with three data patterns. It compares each result against a byte-by-byte model. A design that inverts the index for the wrong side would swap left and right behaviour on one byte order only. A design that decodes addr[2] for word forms would give a different result for the two halves of an aligned doubleword.

Index 0 and the top index are the edges where a shift moves the whole value or one byte. An off-by-one in the mask there would either drop a byte or keep a stale byte. Data patterns with bit 31 both set and clear check the word sign extension. Idle cycles with changed inputs show whether the output is held.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
   // Operation code bit positions: bit 1 selects store, bit 0 selects right.
   localparam int OP_STORE_BIT = 1;
   localparam int OP_RIGHT_BIT = 0;
   localparam logic [1:0] OP_LOAD_LEFT   = 2'd0;
   localparam logic [1:0] OP_LOAD_RIGHT  = 2'd1;
   localparam logic [1:0] OP_STORE_LEFT  = 2'd2;
   localparam logic [1:0] OP_STORE_RIGHT = 2'd3;
endpackage

// File: rtl/pwm_byte_index.sv
module pwm_byte_index #(
   parameter  int XLEN = 64,
   localparam int DIW  = $clog2(XLEN / 8),
   localparam int WIW  = $clog2(XLEN / 16)
) (
   input  logic [DIW-1:0] addr,
   input  logic           right,
   input  logic           big_endian,
   output logic [WIW-1:0] s_word,
   output logic [DIW-1:0] s_dbl
);
   logic invert;

   // Left forms flip on little-endian, right forms flip on big-endian (R1)
   assign invert = right ? big_endian : ~big_endian;
   assign s_word = addr[WIW-1:0] ^ {WIW{invert}};
   assign s_dbl  = addr ^ {DIW{invert}};
endmodule

// File: rtl/pwm_lane.sv
module pwm_lane #(
   parameter  int LW = 64,
   localparam int NB = LW / 8,
   localparam int SW = $clog2(NB)
) (
   input  logic [SW-1:0] s,
   input  logic          store,
   input  logic          right,
   input  logic [LW-1:0] reg_v,
   input  logic [LW-1:0] mem_v,
   output logic [LW-1:0] res,
   output logic [NB-1:0] bmask
);
   logic [LW-1:0]  src, keep, shifted, bitmask;
   logic [SW+2:0]  shamt;
   logic           upward;

   if (LW < 16 || (LW % 8) != 0) begin : g_bad_lane
      $error("pwm_lane: LW must be a byte multiple of at least 16");
   end

   // Source travels toward the destination; the other operand fills the rest
   assign src    = store ? reg_v : mem_v;
   assign keep   = store ? mem_v : reg_v;
   // Left load and right store move data toward the upper end
   assign upward = store ? right : ~right;
   assign shamt  = {s, 3'b000};

   always_comb begin
      if (upward) begin
         shifted = src << shamt;
         bmask   = {NB{1'b1}} << s;
      end else begin
         shifted = src >> shamt;
         bmask   = {NB{1'b1}} >> s;
      end
   end

   for (genvar b = 0; b < NB; b++) begin : g_expand
      assign bitmask[8*b +: 8] = {8{bmask[b]}};
   end

   assign res = (shifted & bitmask) | (keep & ~bitmask);
endmodule

// File: rtl/pwm_merge_unit.sv
module pwm_merge_unit #(
   parameter  int XLEN = 64,
   localparam int NB   = XLEN / 8,
   localparam int HALF = XLEN / 2,
   localparam int DIW  = $clog2(NB),
   localparam int WIW  = $clog2(NB / 2)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            in_valid,
   input  logic [DIW-1:0]  in_addr,
   input  logic            in_big_endian,
   input  logic [1:0]      in_op,
   input  logic            in_dbl,
   input  logic [XLEN-1:0] in_reg,
   input  logic [XLEN-1:0] in_mem,
   output logic            out_valid,
   output logic [XLEN-1:0] out_data,
   output logic [NB-1:0]   out_be
);
   import pwm_pkg::*;

   if (XLEN < 32 || (XLEN & (XLEN - 1)) != 0) begin : g_bad_xlen
      $error("pwm_merge_unit: XLEN must be a power of two of at least 32");
   end

   logic            is_store, is_right;
   logic [WIW-1:0]  s_word;
   logic [DIW-1:0]  s_dbl;
   logic [HALF-1:0] word_res;
   logic [NB/2-1:0] word_mask;
   logic [XLEN-1:0] dbl_res;
   logic [NB-1:0]   dbl_mask;
   logic [XLEN-1:0] nxt_data;
   logic [NB-1:0]   nxt_be;

   assign is_store = in_op[OP_STORE_BIT];
   assign is_right = in_op[OP_RIGHT_BIT];

   pwm_byte_index #(.XLEN(XLEN)) i_index (
      .addr       (in_addr),
      .right      (is_right),
      .big_endian (in_big_endian),
      .s_word     (s_word),
      .s_dbl      (s_dbl)
   );

   pwm_lane #(.LW(HALF)) i_word_lane (
      .s     (s_word),
      .store (is_store),
      .right (is_right),
      .reg_v (in_reg[HALF-1:0]),
      .mem_v (in_mem[HALF-1:0]),
      .res   (word_res),
      .bmask (word_mask)
   );

   pwm_lane #(.LW(XLEN)) i_dbl_lane (
      .s     (s_dbl),
      .store (is_store),
      .right (is_right),
      .reg_v (in_reg),
      .mem_v (in_mem),
      .res   (dbl_res),
      .bmask (dbl_mask)
   );

   always_comb begin
      if (in_dbl)
         nxt_data = dbl_res;
      else if (is_store)
         nxt_data = {{HALF{1'b0}}, word_res};
      else
         nxt_data = {{HALF{word_res[HALF-1]}}, word_res};

      if (!is_store)
         nxt_be = '0;
      else if (in_dbl)
         nxt_be = dbl_mask;
      else
         nxt_be = {{(NB/2){1'b0}}, word_mask};
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
         out_be    <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_data <= nxt_data;
            out_be   <= nxt_be;
         end
      end
   end

   a_r8_latency: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!out_valid && $stable(out_data) && $stable(out_be)));
   a_r6_word_sign: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !in_dbl && !in_op[OP_STORE_BIT])
         |=> out_data[XLEN-1:HALF] == {HALF{out_data[HALF-1]}});
   a_r6_word_store_upper: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !in_dbl && in_op[OP_STORE_BIT])
         |=> (out_data[XLEN-1:HALF] == '0 && out_be[NB-1:NB/2] == '0));
   a_r7_load_no_be: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !in_op[OP_STORE_BIT]) |=> out_be == '0);
   a_r4_left_store_low_byte: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_op == OP_STORE_LEFT) |=> out_be[0]);
   a_r5_right_store_top_byte: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_op == OP_STORE_RIGHT && in_dbl) |=> out_be[NB-1]);
endmodule

// File: tb/test_pwm_merge_unit.sv
module test_pwm_merge_unit;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        in_valid;
   logic [2:0]  in_addr;
   logic        in_big_endian;
   logic [1:0]  in_op;
   logic        in_dbl;
   logic [63:0] in_reg, in_mem;
   logic        out_valid;
   logic [63:0] out_data;
   logic [7:0]  out_be;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   pwm_merge_unit i_pwm_merge_unit (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_addr(in_addr),
      .in_big_endian(in_big_endian), .in_op(in_op), .in_dbl(in_dbl),
      .in_reg(in_reg), .in_mem(in_mem), .out_valid(out_valid),
      .out_data(out_data), .out_be(out_be));

   task automatic chk(input bit ok, input string req, input logic [63:0] act,
                      input logic [63:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Byte-by-byte model of the requirements
   task automatic model(input logic [1:0] op, input bit dbl, input logic [2:0] addr,
                        input bit big, input logic [63:0] r, input logic [63:0] m,
                        output logic [63:0] res, output logic [7:0] be);
      int nb = dbl ? 8 : 4;
      int s  = dbl ? int'(addr) : int'(addr[1:0]);
      bit right = op[0];
      bit inv = right ? big : !big;
      if (inv) s = s ^ (nb - 1);
      res = 64'h0;
      be  = 8'h0;
      for (int b = 0; b < nb; b++) begin
         case (op)
            2'd0: res[8*b +: 8] = (b >= s) ? m[8*(b-s) +: 8] : r[8*b +: 8];
            2'd1: res[8*b +: 8] = (b + s <= nb - 1) ? m[8*(b+s) +: 8] : r[8*b +: 8];
            2'd2: if (b + s <= nb - 1) begin
                     res[8*b +: 8] = r[8*(b+s) +: 8]; be[b] = 1'b1;
                  end else res[8*b +: 8] = m[8*b +: 8];
            default: if (b >= s) begin
                     res[8*b +: 8] = r[8*(b-s) +: 8]; be[b] = 1'b1;
                  end else res[8*b +: 8] = m[8*b +: 8];
         endcase
      end
      if (!dbl && !op[1]) res[63:32] = {32{res[31]}};
   endtask

   function automatic string op_req(input logic [1:0] op);
      case (op)
         2'd0: return "R1 R2 left load";
         2'd1: return "R1 R3 right load";
         2'd2: return "R1 R4 left store";
         default: return "R1 R5 right store";
      endcase
   endfunction

   task automatic issue(input logic [1:0] op, input bit dbl, input logic [2:0] addr,
                        input bit big, input logic [63:0] r, input logic [63:0] m);
      @(negedge clk);
      in_valid = 1'b1; in_op = op; in_dbl = dbl; in_addr = addr;
      in_big_endian = big; in_reg = r; in_mem = m;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   initial begin
      logic [63:0] pats_r [3];
      logic [63:0] pats_m [3];
      logic [63:0] er, er2, held_d;
      logic [7:0]  eb, eb2, held_b;
      pats_r[0] = 64'h0123456789ABCDEF; pats_m[0] = 64'hF0E1D2C3B4A59687;
      pats_r[1] = 64'hFEDCBA9876543210; pats_m[1] = 64'h0011223344556677;
      pats_r[2] = 64'h8899AABB7C6D5E4F; pats_m[2] = 64'h90A1B2C3D4E5F607;

      rst_n = 1'b0; in_valid = 1'b0; in_addr = '0; in_big_endian = 1'b0;
      in_op = '0; in_dbl = 1'b0; in_reg = '0; in_mem = '0;
      repeat (3) @(negedge clk);
      // R9: outputs zero during reset
      chk(out_valid == 1'b0, "R9 reset valid", {63'h0, out_valid}, 64'h0);
      chk(out_data == 64'h0, "R9 reset data", out_data, 64'h0);
      chk(out_be == 8'h0, "R9 reset be", {56'h0, out_be}, 64'h0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(out_valid == 1'b0, "R8 idle after reset", {63'h0, out_valid}, 64'h0);

      // Exhaustive sweep over op, size, address, byte order and data patterns
      for (int p = 0; p < 3; p++)
         for (int o = 0; o < 4; o++)
            for (int d = 0; d < 2; d++)
               for (int a = 0; a < 8; a++)
                  for (int e = 0; e < 2; e++) begin
                     model(2'(o), d[0], 3'(a), e[0], pats_r[p], pats_m[p], er, eb);
                     issue(2'(o), d[0], 3'(a), e[0], pats_r[p], pats_m[p]);
                     chk(out_valid == 1'b1, "R8 valid latency", {63'h0, out_valid}, 64'h1);
                     chk(out_data == er, op_req(2'(o)), out_data, er);
                     chk(out_be == eb, "R7 byte enables", {56'h0, out_be}, {56'h0, eb});
                  end

      // R6: explicit sign extension on a word left load (big-endian, addr 0 -> full word)
      issue(2'd0, 1'b0, 3'd0, 1'b1, 64'h0, 64'h00000000_80000001);
      chk(out_data == 64'hFFFFFFFF_80000001, "R6 word sign extend", out_data,
          64'hFFFFFFFF_80000001);
      // R6: word store leaves upper half zero even with set upper register bits
      issue(2'd3, 1'b0, 3'd0, 1'b1, 64'hFFFFFFFF_11223344, 64'hFFFFFFFF_55667788);
      chk(out_data[63:32] == 32'h0, "R6 word store upper zero", out_data,
          {32'h0, out_data[31:0]});

      // R1: addr[2] has no effect on word forms
      for (int o = 0; o < 4; o++) begin
         issue(2'(o), 1'b0, 3'd1, 1'b0, pats_r[0], pats_m[1]);
         er2 = out_data; eb2 = out_be;
         issue(2'(o), 1'b0, 3'd5, 1'b0, pats_r[0], pats_m[1]);
         chk(out_data == er2 && out_be == eb2, "R1 word ignores addr bit 2",
             out_data, er2);
      end

      // R8: held while idle even when inputs change
      issue(2'd2, 1'b1, 3'd3, 1'b0, pats_r[1], pats_m[0]);
      held_d = out_data; held_b = out_be;
      in_op = 2'd1; in_addr = 3'd6; in_reg = 64'hDEADBEEFCAFEF00D; in_mem = 64'h1;
      @(negedge clk);
      chk(out_valid == 1'b0, "R8 valid drops", {63'h0, out_valid}, 64'h0);
      chk(out_data == held_d, "R8 data held", out_data, held_d);
      chk(out_be == held_b, "R8 be held", {56'h0, out_be}, {56'h0, held_b});
      @(negedge clk);
      chk(out_data == held_d, "R8 data still held", out_data, held_d);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule